// File: doc/BRIEF.md
# Calendar Alarm Comparator with Repeat Counting

This block watches the current calendar time and date, supplied as BCD words by an external calendar counter, and compares them with a programmed alarm time and date. Matching is evaluated only on timing strobes: a one-second tick for most modes and a half-second strobe for the fastest mode. A 4-bit mask code selects which fields take part in the comparison, from "every half second" up to "once a year". When the alarm is enabled and the selected fields agree on a tick, the block raises an alarm event. The event produces a one-cycle pulse and sets a sticky interrupt flag.

An 8-bit repeat count limits the number of events. In normal mode each event lowers the count by one, and the event that finds the count at zero turns the alarm off. In chime mode the count wraps from zero to 0xFF and the enable bit is left alone, so the alarm recurs until software turns it off. Software reaches the block through a small register port. Writes are staged for one cycle before they take effect. Each write can be a plain write, a bit-set or a bit-clear. A sync status bit tells software when reprogramming is unsafe: during a window just before each second tick, and while a staged write is still pending.

Top module: `rtc_alarm_unit`

## Requirements
- R1: After reset the control word reads 0 apart from the sync bit, the alarm time and date read 0, and the alarm pulse and interrupt flag are low.
- R2: The register addresses are: 0 control, 1 alarm time, 2 alarm date, 3 status. In the control word, bit 15 is the enable, bit 14 the chime, bit 12 the sync status (read only), bits 11:8 the mask code and bits 7:0 the repeat count. A write is captured on one clock edge and its new value can be read after the next edge.
- R3: Write op 0 (and op 3) writes the value. Op 1 sets the bits that are 1 in the data. Op 2 clears the bits that are 1 in the data. A clear of 0xCFFF followed at once by a set of 0xC600 leaves the control word at 0xC600.
- R4: In the alarm time word the BCD hours are in [31:24], the minutes in [23:16] and the seconds in [15:8]. In the date word the year is in [31:24], the month in [23:16], the day of month in [15:8] and the weekday in [7:0]. On a second tick the mask codes compare these fields: 0010 the seconds units digit; 0011 the seconds; 0100 the minutes units digit and the seconds; 0101 and 0110 the minutes and seconds; 0111 the hours, minutes and seconds; 1000 the time and the weekday; 1001 the time and the day of month; 1010 the time, the day and the month.
- R5: Mask 0000 matches on every half-second strobe. Mask 0001 matches on every second tick. Codes above 1010 never match.
- R6: With chime at 0, an event decrements a non-zero repeat count by one. An event that finds the count at 0 still fires, and it clears the enable bit.
- R7: With chime at 1, each event decrements the count and wraps it from 0x00 to 0xFF, and the enable bit stays set.
- R8: While the enable bit is 0, no match produces a pulse or sets the flag.
- R9: An event drives the alarm pulse high for exactly one cycle, on the edge after the strobe, and sets the interrupt flag. The flag stays set until software writes 1 to bit 0 of the status register.
- R10: The sync bit reads 1 while a staged write is pending, and during the last SYNC_WIN cycles of each CYC_PER_SEC-cycle second, counted from the last tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_op | input | 2 | Write kind: 0/3 write, 1 set bits, 2 clear bits |
| wr_addr | input | 2 | Register address for writes |
| wr_data | input | 32 | Write data or bit mask |
| rd_addr | input | 2 | Register address for reads |
| rd_data | output | 32 | Read data (combinational) |
| sec_tick | input | 1 | One-second strobe |
| half_tick | input | 1 | Half-second strobe |
| now_time | input | 32 | Current BCD time word |
| now_date | input | 32 | Current BCD date word |
| alarm_pulse | output | 1 | One-cycle alarm event pulse |
| alarm_irq | output | 1 | Sticky alarm interrupt flag |

## Verification
The bench targets the repeat-count boundary. A count of zero in normal mode must still fire and then disable the alarm. A design that checks for zero before firing would drop the last event, and one that fails to clear the enable would keep ringing. In chime mode, a design that saturates instead of wrapping would read 0x00 rather than 0xFF, and a design that clears the enable would stop the alarm too early. The bench also runs near-miss field patterns for each mask code, where a wrongly chosen field changes the match result. A clear immediately followed by a set catches a design that loses the merge between staged writes. The sync window is probed at the exact cycle where it should open, which exposes an off-by-one in the cycle counter.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_TIME = 2'd1;
  localparam logic [1:0] ADDR_DATE = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd3;

  localparam logic [1:0] OP_SET = 2'd1;
  localparam logic [1:0] OP_CLR = 2'd2;

  typedef struct packed {
    logic       en;
    logic       chime;
    logic [3:0] mask;
    logic [7:0] cnt;
  } ctrl_t;

  function automatic logic [31:0] ctrl_pack(input ctrl_t c, input logic sync);
    ctrl_pack = {16'd0, c.en, c.chime, 1'b0, sync, c.mask, c.cnt};
  endfunction

  function automatic ctrl_t ctrl_unpack(input logic [31:0] w);
    ctrl_t c;
    c.en    = w[15];
    c.chime = w[14];
    c.mask  = w[11:8];
    c.cnt   = w[7:0];
    return c;
  endfunction

  function automatic logic [31:0] apply_op(input logic [1:0] op,
                                           input logic [31:0] cur,
                                           input logic [31:0] val);
    case (op)
      OP_SET:  apply_op = cur | val;
      OP_CLR:  apply_op = cur & ~val;
      default: apply_op = val;
    endcase
  endfunction

endpackage

// File: rtl/rtc_alarm_sync.sv
module rtc_alarm_sync #(
  parameter int CYC_PER_SEC = 32768,
  parameter int SYNC_WIN    = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sec_tick,
  output logic window_o
);
  localparam int CW = $clog2(CYC_PER_SEC + 1);
  localparam logic [CW-1:0] LIM = CW'(CYC_PER_SEC - 1);
  localparam logic [CW-1:0] THR = CW'(CYC_PER_SEC - SYNC_WIN);

  logic [CW-1:0] cyc_q, cyc_d;

  always_comb begin
    cyc_d = cyc_q;
    if (sec_tick)         cyc_d = '0;
    else if (cyc_q < LIM) cyc_d = cyc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc_q <= '0;
    else        cyc_q <= cyc_d;
  end

  assign window_o = (cyc_q >= THR);

  // R10
  win_drop_only_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    window_o |=> (window_o || $past(sec_tick)));

endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match (
  input  logic [3:0]  mask,
  input  logic [31:0] al_time,
  input  logic [31:0] al_date,
  input  logic [31:0] now_time,
  input  logic [31:0] now_date,
  input  logic        sec_tick,
  input  logic        half_tick,
  output logic        hit_o
);
  logic sec_u, sec_f, min_u, min_f, hr_f, wday_f, mday_f, mon_f;

  always_comb begin
    sec_u  = (al_time[11:8]  == now_time[11:8]);
    sec_f  = (al_time[15:8]  == now_time[15:8]);
    min_u  = (al_time[19:16] == now_time[19:16]);
    min_f  = (al_time[23:16] == now_time[23:16]);
    hr_f   = (al_time[31:24] == now_time[31:24]);
    wday_f = (al_date[7:0]   == now_date[7:0]);
    mday_f = (al_date[15:8]  == now_date[15:8]);
    mon_f  = (al_date[23:16] == now_date[23:16]);
  end

  always_comb begin
    hit_o = 1'b0;
    case (mask)
      4'b0000: hit_o = half_tick;
      4'b0001: hit_o = sec_tick;
      4'b0010: hit_o = sec_tick && sec_u;
      4'b0011: hit_o = sec_tick && sec_f;
      4'b0100: hit_o = sec_tick && sec_f && min_u;
      4'b0101,
      4'b0110: hit_o = sec_tick && sec_f && min_f;
      4'b0111: hit_o = sec_tick && sec_f && min_f && hr_f;
      4'b1000: hit_o = sec_tick && sec_f && min_f && hr_f && wday_f;
      4'b1001: hit_o = sec_tick && sec_f && min_f && hr_f && mday_f;
      4'b1010: hit_o = sec_tick && sec_f && min_f && hr_f && mday_f && mon_f;
      default: hit_o = 1'b0;
    endcase
  end

  // R5
  no_hit_without_strobe_chk: assert final (hit_o == 1'b0 || sec_tick || half_tick);

endmodule

// File: rtl/rtc_alarm_regs.sv
module rtc_alarm_regs
  import rtc_alarm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_op,
  input  logic [1:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic        hit_i,
  output ctrl_t       ctrl_o,
  output logic [31:0] al_time_o,
  output logic [31:0] al_date_o,
  output logic        pend_o,
  output logic        pulse_o,
  output logic        irq_o
);
  logic        stg_v_q, stg_v_d;
  logic [1:0]  stg_op_q, stg_op_d, stg_ad_q, stg_ad_d;
  logic [31:0] stg_dt_q, stg_dt_d;
  ctrl_t       ctrl_q, ctrl_d;
  logic [31:0] tim_q, tim_d, dat_q, dat_d;
  logic        pulse_q, pulse_d, irq_q, irq_d;
  logic        ev, ctrl_apply;

  assign ev         = hit_i && ctrl_q.en;
  assign ctrl_apply = stg_v_q && (stg_ad_q == ADDR_CTRL);

  always_comb begin
    stg_v_d  = wr_en;
    stg_op_d = stg_op_q;
    stg_ad_d = stg_ad_q;
    stg_dt_d = stg_dt_q;
    if (wr_en) begin
      stg_op_d = wr_op;
      stg_ad_d = wr_addr;
      stg_dt_d = wr_data;
    end
  end

  always_comb begin
    ctrl_d  = ctrl_q;
    tim_d   = tim_q;
    dat_d   = dat_q;
    pulse_d = ev;
    irq_d   = irq_q;
    if (ev) begin
      irq_d = 1'b1;
      if (!ctrl_q.chime && ctrl_q.cnt == 8'd0) ctrl_d.en = 1'b0;
      else                                     ctrl_d.cnt = ctrl_q.cnt - 8'd1;
    end
    if (stg_v_q) begin
      case (stg_ad_q)
        ADDR_CTRL: ctrl_d = ctrl_unpack(apply_op(stg_op_q, ctrl_pack(ctrl_q, 1'b0), stg_dt_q));
        ADDR_TIME: tim_d  = apply_op(stg_op_q, tim_q, stg_dt_q);
        ADDR_DATE: dat_d  = apply_op(stg_op_q, dat_q, stg_dt_q);
        default:   if (stg_dt_q[0] && !ev) irq_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_v_q  <= 1'b0;
      stg_op_q <= '0;
      stg_ad_q <= '0;
      stg_dt_q <= '0;
      ctrl_q   <= '0;
      tim_q    <= '0;
      dat_q    <= '0;
      pulse_q  <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      stg_v_q  <= stg_v_d;
      stg_op_q <= stg_op_d;
      stg_ad_q <= stg_ad_d;
      stg_dt_q <= stg_dt_d;
      ctrl_q   <= ctrl_d;
      tim_q    <= tim_d;
      dat_q    <= dat_d;
      pulse_q  <= pulse_d;
      irq_q    <= irq_d;
    end
  end

  assign ctrl_o    = ctrl_q;
  assign al_time_o = tim_q;
  assign al_date_o = dat_q;
  assign pend_o    = stg_v_q;
  assign pulse_o   = pulse_q;
  assign irq_o     = irq_q;

  // R9
  pulse_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> irq_q);

  // R7
  chime_keeps_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev && ctrl_q.chime && !ctrl_apply) |=> ctrl_q.en);

  // R6
  auto_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev && !ctrl_q.chime && ctrl_q.cnt == 8'd0 && !ctrl_apply) |=> !ctrl_q.en);

  // R6
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev && !ctrl_apply && (ctrl_q.chime || ctrl_q.cnt != 8'd0))
      |=> (ctrl_q.cnt == $past(ctrl_q.cnt) - 8'd1));

  // R8
  idle_ctrl_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev && !ctrl_apply) |=> $stable(ctrl_q));

endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit
  import rtc_alarm_pkg::*;
#(
  parameter int CYC_PER_SEC = 32768,
  parameter int SYNC_WIN    = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_op,
  input  logic [1:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [1:0]  rd_addr,
  output logic [31:0] rd_data,
  input  logic        sec_tick,
  input  logic        half_tick,
  input  logic [31:0] now_time,
  input  logic [31:0] now_date,
  output logic        alarm_pulse,
  output logic        alarm_irq
);
  ctrl_t       ctrl;
  logic [31:0] al_time, al_date;
  logic        hit, pend, window, sync;

  rtc_alarm_sync #(.CYC_PER_SEC(CYC_PER_SEC), .SYNC_WIN(SYNC_WIN)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .sec_tick (sec_tick),
    .window_o (window)
  );

  rtc_alarm_match u_match (
    .mask      (ctrl.mask),
    .al_time   (al_time),
    .al_date   (al_date),
    .now_time  (now_time),
    .now_date  (now_date),
    .sec_tick  (sec_tick),
    .half_tick (half_tick),
    .hit_o     (hit)
  );

  rtc_alarm_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_op     (wr_op),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .hit_i     (hit),
    .ctrl_o    (ctrl),
    .al_time_o (al_time),
    .al_date_o (al_date),
    .pend_o    (pend),
    .pulse_o   (alarm_pulse),
    .irq_o     (alarm_irq)
  );

  assign sync = pend || window;

  always_comb begin
    case (rd_addr)
      ADDR_CTRL: rd_data = ctrl_pack(ctrl, sync);
      ADDR_TIME: rd_data = al_time;
      ADDR_DATE: rd_data = al_date;
      default:   rd_data = {31'd0, alarm_irq};
    endcase
  end

  // R10
  pending_shows_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en) |-> rd_data_sync_bit());

  function automatic logic rd_data_sync_bit();
    return ctrl_pack(ctrl, sync) >> 12 & 32'd1 ? 1'b1 : 1'b0;
  endfunction

endmodule

// File: tb/rtc_alarm_unit_tb.sv
module rtc_alarm_unit_tb;
  localparam int CYC = 100;
  localparam int WIN = 32;
  localparam logic [31:0] AT = 32'h23352300;
  localparam logic [31:0] AD = 32'h06111301;

  typedef struct packed {
    logic [3:0]  mask;
    logic [31:0] ntime;
    logic [31:0] ndate;
    logic        exp;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{4'h6, 32'h10352300, 32'h01010101, 1'b1},  // R4 hourly
    '{4'h6, 32'h10362300, 32'h01010101, 1'b0},  // R4 minute differs
    '{4'h5, 32'h02352300, 32'h01010101, 1'b1},  // R4
    '{4'h7, 32'h23352300, 32'h01010101, 1'b1},  // R4 daily
    '{4'h7, 32'h22352300, 32'h06111301, 1'b0},  // R4 hour differs
    '{4'h2, 32'h01024300, 32'h01010101, 1'b1},  // R4 seconds units
    '{4'h3, 32'h01022400, 32'h01010101, 1'b0},  // R4
    '{4'h4, 32'h00452300, 32'h01010101, 1'b1},  // R4 minute units
    '{4'h8, 32'h23352300, 32'h07010201, 1'b1},  // R4 weekday
    '{4'h9, 32'h23352300, 32'h07011401, 1'b0},  // R4 day differs
    '{4'h9, 32'h23352300, 32'h07011307, 1'b1},  // R4 day of month
    '{4'hA, 32'h23352300, 32'h09111302, 1'b1},  // R4 yearly
    '{4'hB, 32'h23352300, 32'h06111301, 1'b0},  // R5 invalid code
    '{4'h1, 32'h00000000, 32'h00000000, 1'b1}   // R5 every second
  };

  logic clk, rst_n, wr_en, sec_tick, half_tick, alarm_pulse, alarm_irq;
  logic [1:0] wr_op, wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data, now_time, now_date;
  int checks, fails;

  rtc_alarm_unit #(.CYC_PER_SEC(CYC), .SYNC_WIN(WIN)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_op(wr_op), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .sec_tick(sec_tick),
    .half_tick(half_tick), .now_time(now_time), .now_date(now_date),
    .alarm_pulse(alarm_pulse), .alarm_irq(alarm_irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] op, input logic [1:0] ad, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_op = op; wr_addr = ad; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] ad, output logic [31:0] d);
    rd_addr = ad;
    #1 d = rd_data;
  endtask

  task automatic tick(input logic half);
    @(negedge clk);
    if (half) half_tick = 1'b1; else sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0; half_tick = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    checks = 0; fails = 0;
    rst_n = 1'b0; wr_en = 1'b0; wr_op = '0; wr_addr = '0; wr_data = '0;
    rd_addr = '0; sec_tick = 1'b0; half_tick = 1'b0; now_time = '0; now_date = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();

    rd(2'd0, r); check("R1 ctrl", r & ~32'h1000, 32'h0);
    rd(2'd1, r); check("R1 time", r, 32'h0);
    check("R1 pulse", {31'd0, alarm_pulse}, 32'd0);
    check("R1 irq", {31'd0, alarm_irq}, 32'd0);

    wr(2'd0, 2'd1, AT); settle();
    wr(2'd0, 2'd2, AD); settle();
    rd(2'd1, r); check("R2 time readback", r, AT);
    rd(2'd2, r); check("R2 date readback", r, AD);

    for (int i = 0; i < NV; i++) begin
      wr(2'd0, 2'd0, 32'hC010 | (32'(VEC[i].mask) << 8)); settle();
      now_time = VEC[i].ntime; now_date = VEC[i].ndate;
      tick(1'b0);
      check(VEC[i].mask > 4'hA ? "R5 vector" : "R4 vector", {31'd0, alarm_pulse}, {31'd0, VEC[i].exp});
    end

    // R5 half-second mode
    wr(2'd0, 2'd0, 32'hC010); settle();
    tick(1'b1);
    check("R5 half strobe", {31'd0, alarm_pulse}, 32'd1);
    tick(1'b0);
    check("R5 mask0 ignores sec tick", {31'd0, alarm_pulse}, 32'd0);

    // R9 flag sticky, single pulse, W1C
    settle();
    check("R9 pulse one cycle", {31'd0, alarm_pulse}, 32'd0);
    check("R9 flag sticky", {31'd0, alarm_irq}, 32'd1);
    wr(2'd0, 2'd3, 32'h1); settle();
    check("R9 flag cleared", {31'd0, alarm_irq}, 32'd0);

    // R6 normal-mode counting and auto-disable
    wr(2'd0, 2'd0, 32'h8101); settle();
    tick(1'b0);
    check("R6 event with count 1", {31'd0, alarm_pulse}, 32'd1);
    rd(2'd0, r); check("R6 count dec", r & ~32'h1000, 32'h8100);
    tick(1'b0);
    check("R6 event at count 0", {31'd0, alarm_pulse}, 32'd1);
    rd(2'd0, r); check("R6 enable cleared", r & ~32'h1000, 32'h0100);
    wr(2'd0, 2'd3, 32'h1); settle();
    tick(1'b0);
    check("R8 disabled no pulse", {31'd0, alarm_pulse}, 32'd0);
    check("R8 disabled no flag", {31'd0, alarm_irq}, 32'd0);

    // R7 chime wrap
    wr(2'd0, 2'd0, 32'hC100); settle();
    tick(1'b0);
    check("R7 chime event", {31'd0, alarm_pulse}, 32'd1);
    rd(2'd0, r); check("R7 wrap keep enable", r & ~32'h1000, 32'hC1FF);
    tick(1'b0);
    rd(2'd0, r); check("R7 keeps counting", r & ~32'h1000, 32'hC1FE);

    // R3 clear then set back to back
    wr(2'd2, 2'd0, 32'hCFFF);
    wr(2'd1, 2'd0, 32'hC600);
    settle();
    rd(2'd0, r); check("R3 clear+set", r & ~32'h1000, 32'hC600);

    // R10 sync window and pending write
    wr(2'd0, 2'd0, 32'h0); settle();
    tick(1'b0);
    repeat (67) @(negedge clk);
    rd(2'd0, r); check("R10 before window", {31'd0, r[12]}, 32'd0);
    @(negedge clk);
    rd(2'd0, r); check("R10 window open", {31'd0, r[12]}, 32'd1);
    tick(1'b0);
    rd(2'd0, r); check("R10 closed after tick", {31'd0, r[12]}, 32'd0);
    @(negedge clk);
    wr_en = 1'b1; wr_op = 2'd0; wr_addr = 2'd1; wr_data = AT;
    @(negedge clk);
    wr_en = 1'b0;
    rd(2'd0, r); check("R10 pending write", {31'd0, r[12]}, 32'd1);
    settle();
    rd(2'd0, r); check("R10 pending done", {31'd0, r[12]}, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule